// File: doc/BRIEF.md
# Oversampled Data Recovery Bit Picker

The block takes serial data that a bank of slow multi-phase samplers has already captured at several samples per data bit. The samplers deliver those samples as a 20-bit parallel word on every core clock. The block then chooses which single sample stands for each data bit. Consecutive chosen positions are spaced by a programmable step that need not be a whole number. The step has an integer part and a 16-bit fraction. A 16-bit phase accumulator adds the fraction once for each recovered bit. When that addition carries, the spacing is the integer part plus one. Otherwise it is the integer part alone. A step of 2.4 therefore produces a repeating mix of 2s and 3s. At about five samples per bit, no chosen sample lies further than about a fifth of a bit period from its ideal instant.

Recovery logic outside the block computes the step, for example from a frequency estimate. It can replace the step on any cycle, and the new value applies at once. The same logic may watch the unused samples for transitions and move the pick position by one sample in either direction through the nudge input. Each cycle the block reports up to 10 recovered bits, oldest first, with a valid mask.

Top module: `frac_bit_picker`

## Requirements
- R1: While `rst` is high, `recBits` and `recValid` are zero after each clock edge. Reset sets the pick pointer to 0 and the accumulator to 0, and reloads the step register with 5.0 (0x50000).
- R2: `sampleWord[0]` is the oldest sample. Each recovered bit is a copy of one sample of the word presented before a clock edge, and it appears on the outputs right after that same edge. The first pick of a word is at the carried pointer.
- R3: The step is coded as {integer[19:16], fraction[15:0]}. After each pick, the fraction is added to the 16-bit accumulator. The next pick is integer+1 samples later if that addition carries out of bit 15, and integer samples later if it does not.
- R4: Picks go on while the position is below 20. The first position at or beyond 20, minus 20, becomes the starting pointer for the next word, so a large step crosses word boundaries with its offset kept.
- R5: `recBits[i]` is the i-th pick of the word, oldest at bit 0. `recValid` has ones in bits 0 to n-1 for n picks and zeros above, and n is at least 1 outside reset.
- R6: When `loadStep` is high, `stepIn` governs every step computed in that cycle and is kept for later cycles. The accumulator is not cleared. Without `loadStep` the held step is used.
- R7: A high `nudge` moves that cycle's starting pointer one sample later when `nudgeUp` is 1 and one sample earlier when it is 0. An earlier move from pointer 0 has no effect.
- R8: An integer part of 0 or 1 is treated as 2, so that no word yields more than 10 picks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleWord | input | 20 | Oversampled bits of this cycle, bit 0 oldest |
| stepIn | input | 20 | New step, integer in [19:16], fraction in [15:0] |
| loadStep | input | 1 | Applies `stepIn` from this cycle on |
| nudge | input | 1 | One-sample shift of the start pointer this cycle |
| nudgeUp | input | 1 | Direction of the shift: 1 later, 0 earlier |
| recBits | output | 10 | Recovered bits, oldest at bit 0 |
| recValid | output | 10 | Valid mask for `recBits` |

## Verification
Every result comes out one clock edge after its stimulus. The word, step, load and nudge applied before edge k decide `recBits` and `recValid` as seen right after edge k. The pointer and accumulator that edge k leaves behind show up only in the picks of edge k+1. The bench therefore drives one cycle of inputs, waits for the edge, samples one time unit later and compares against a reference model that it advances by exactly one word. Reset results are sampled the same way after an edge taken with `rst` high.

// File: rtl/bp_pkg.sv
package bp_pkg;
  parameter int SAMPLE_W   = 20;
  parameter int FRAC_W     = 16;
  parameter int INT_W      = 4;
  parameter int STEP_W     = INT_W + FRAC_W;
  parameter int MIN_INT    = 2;
  parameter int MAX_OUT    = (SAMPLE_W + MIN_INT - 1) / MIN_INT;
  parameter int POS_W      = $clog2(SAMPLE_W);
  parameter int PTR_W      = $clog2(2 * SAMPLE_W + (1 << INT_W));
  parameter logic [STEP_W-1:0] STEP_RESET = STEP_W'(5 << FRAC_W);

  // strobes from the pick control to the datapath
  typedef struct packed {
    logic                            live;
    logic [MAX_OUT-1:0]              pickEn;
    logic [MAX_OUT-1:0][POS_W-1:0]   pickPos;
  } pickCtl_t;
endpackage

// File: rtl/bp_pick_ctrl.sv
module bp_pick_ctrl
  import bp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] stepIn,
  input  logic              loadStep,
  input  logic              nudge,
  input  logic              nudgeUp,
  output pickCtl_t          ctl
);
  logic [PTR_W-1:0]  ptrQ, ptrNext, startPtr;
  logic [FRAC_W-1:0] accQ, accNext;
  logic [STEP_W-1:0] stepQ, stepEff;
  logic [INT_W-1:0]  intRaw, intEff;
  logic [FRAC_W-1:0] fracPart;

  always_comb begin
    stepEff  = loadStep ? stepIn : stepQ;
    intRaw   = stepEff[FRAC_W +: INT_W];
    fracPart = stepEff[FRAC_W-1:0];
    intEff   = (intRaw < INT_W'(MIN_INT)) ? INT_W'(MIN_INT) : intRaw;
  end

  always_comb begin
    if (!nudge)       startPtr = ptrQ;
    else if (nudgeUp) startPtr = ptrQ + PTR_W'(1);
    else if (ptrQ == '0) startPtr = '0;
    else              startPtr = ptrQ - PTR_W'(1);
  end

  // unrolled chain of picks for one word
  always_comb begin
    logic [PTR_W-1:0]  pos;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;
    pos = startPtr;
    acc = accQ;
    sum = '0;
    ctl.live    = !rst;
    ctl.pickEn  = '0;
    ctl.pickPos = '0;
    for (int i = 0; i < MAX_OUT; i++) begin
      if (pos < PTR_W'(SAMPLE_W)) begin
        ctl.pickEn[i]  = 1'b1;
        ctl.pickPos[i] = pos[POS_W-1:0];
        sum = {1'b0, acc} + {1'b0, fracPart};
        acc = sum[FRAC_W-1:0];
        pos = pos + PTR_W'(intEff) + PTR_W'(sum[FRAC_W]);
      end
    end
    accNext = acc;
    ptrNext = pos - PTR_W'(SAMPLE_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptrQ  <= '0;
      accQ  <= '0;
      stepQ <= STEP_RESET;
    end else begin
      ptrQ  <= ptrNext;
      accQ  <= accNext;
      stepQ <= stepEff;
    end
  end

  // R4
  ptr_carry_chk: assert property (@(posedge clk) disable iff (rst)
    ptrQ < PTR_W'(SAMPLE_W));

  // R6
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !loadStep |=> $stable(stepQ));

  // R3
  acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadStep && stepQ[FRAC_W-1:0] == '0) |=> $stable(accQ));
endmodule

// File: rtl/bp_pick_data.sv
module bp_pick_data
  import bp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sampleWord,
  input  pickCtl_t            ctl,
  output logic [MAX_OUT-1:0]  recBits,
  output logic [MAX_OUT-1:0]  recValid
);
  logic [MAX_OUT-1:0] bitsNext;

  generate
    for (genvar g = 0; g < MAX_OUT; g++) begin : gSel
      assign bitsNext[g] = ctl.pickEn[g] & sampleWord[ctl.pickPos[g]];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !ctl.live) begin
      recBits  <= '0;
      recValid <= '0;
    end else begin
      recBits  <= bitsNext;
      recValid <= ctl.pickEn;
    end
  end

  // R5
  valid_contig_chk: assert property (@(posedge clk) disable iff (rst)
    ((recValid + MAX_OUT'(1)) & recValid) == '0);

  // R5
  first_pick_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> recValid[0]);

  // R2
  bits_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (recBits & ~recValid) == '0);
endmodule

// File: rtl/frac_bit_picker.sv
module frac_bit_picker
  import bp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sampleWord,
  input  logic [STEP_W-1:0]   stepIn,
  input  logic                loadStep,
  input  logic                nudge,
  input  logic                nudgeUp,
  output logic [MAX_OUT-1:0]  recBits,
  output logic [MAX_OUT-1:0]  recValid
);
  pickCtl_t ctl;

  bp_pick_ctrl uCtrl (
    .clk(clk), .rst(rst), .stepIn(stepIn), .loadStep(loadStep),
    .nudge(nudge), .nudgeUp(nudgeUp), .ctl(ctl)
  );

  bp_pick_data uData (
    .clk(clk), .rst(rst), .sampleWord(sampleWord), .ctl(ctl),
    .recBits(recBits), .recValid(recValid)
  );
endmodule

// File: tb/frac_bit_picker_test.sv
module frac_bit_picker_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [19:0] sampleWord = '0;
  logic [19:0] stepIn = '0;
  logic loadStep = 1'b0, nudge = 1'b0, nudgeUp = 1'b0;
  logic [9:0] recBits, recValid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int mPtr = 0;
  int mAcc = 0;
  logic [19:0] mStep = 20'h50000;

  frac_bit_picker uut (
    .clk(clk), .rst(rst), .sampleWord(sampleWord), .stepIn(stepIn),
    .loadStep(loadStep), .nudge(nudge), .nudgeUp(nudgeUp),
    .recBits(recBits), .recValid(recValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [19:0] word;
    logic        load;
    logic [19:0] step;
    logic        nud;
    logic        up;
    logic [9:0]  expBits;
    logic [9:0]  expValid;
  } vec_t;

  // starts with pointer 0, accumulator 0
  localparam vec_t TABLE [11] = '{
    '{20'h11111, 1'b1, 20'h40000, 1'b0, 1'b0, 10'h01F, 10'h01F}, // R2 step 4
    '{20'h0000F, 1'b0, 20'h00000, 1'b1, 1'b1, 10'h001, 10'h01F}, // R7 later
    '{20'hAAAAA, 1'b0, 20'h00000, 1'b0, 1'b0, 10'h01F, 10'h01F}, // R4 offset kept
    '{20'hAAAAA, 1'b0, 20'h00000, 1'b1, 1'b0, 10'h000, 10'h01F}, // R7 earlier
    '{20'h49249, 1'b1, 20'h30000, 1'b0, 1'b0, 10'h07F, 10'h07F}, // R6 step 3
    '{20'h49249, 1'b0, 20'h00000, 1'b0, 1'b0, 10'h000, 10'h07F}, // R4
    '{20'hFFFFF, 1'b0, 20'h00000, 1'b0, 1'b0, 10'h03F, 10'h03F}, // R5
    '{20'hFFFFF, 1'b1, 20'h10000, 1'b0, 1'b0, 10'h3FF, 10'h3FF}, // R8 clamp
    '{20'h08001, 1'b1, 20'hF0000, 1'b0, 1'b0, 10'h003, 10'h003}, // R4 step 15
    '{20'h00400, 1'b0, 20'h00000, 1'b0, 1'b0, 10'h001, 10'h001}, // R4 carry
    '{20'h00020, 1'b0, 20'h00000, 1'b0, 1'b0, 10'h001, 10'h001}  // R4 carry
  };

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic runCycle(logic [19:0] w, logic ld, logic [19:0] st,
                          logic nd, logic up);
    sampleWord = w; loadStep = ld; stepIn = st; nudge = nd; nudgeUp = up;
    @(posedge clk);
    #1;
  endtask

  // reference: walk the positions one pick at a time
  task automatic model(logic [19:0] w, logic ld, logic [19:0] st, logic nd,
                       logic up, output logic [9:0] eb, output logic [9:0] ev);
    int ip, fr, p, n, s;
    if (ld) mStep = st;
    ip = int'(mStep[19:16]);
    if (ip < 2) ip = 2;
    fr = int'(mStep[15:0]);
    p = mPtr;
    if (nd) p = up ? p + 1 : ((p > 0) ? p - 1 : 0);
    n = 0; eb = '0; ev = '0;
    while (p < 20) begin
      eb[n] = w[p];
      ev[n] = 1'b1;
      n++;
      s = mAcc + fr;
      mAcc = s % 65536;
      p = p + ip + ((s >= 65536) ? 1 : 0);
    end
    mPtr = p - 20;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [9:0] eb, ev;
    logic [31:0] lfsr;
    logic [19:0] w;
    lfsr = 32'h1D2C3B4A;

    // R1: reset state
    repeat (2) @(posedge clk);
    #1;
    check("R1 bits in reset", recBits, 10'h000);
    check("R1 valid in reset", recValid, 10'h000);
    rst = 1'b0;

    // R2 with the reset step 5.0: picks 0,5,10,15
    runCycle(20'h08421, 1'b0, 20'h0, 1'b0, 1'b0);
    check("R1 reset step bits", recBits, 10'h00F);
    check("R1 reset step valid", recValid, 10'h00F);

    for (int i = 0; i < 11; i++) begin
      runCycle(TABLE[i].word, TABLE[i].load, TABLE[i].step, TABLE[i].nud,
               TABLE[i].up);
      check($sformatf("R2/R4/R5 row %0d bits", i), recBits, TABLE[i].expBits);
      check($sformatf("R5 row %0d valid", i), recValid, TABLE[i].expValid);
    end

    // R3: fractional step 2.4, model continues from pointer 0 acc 0
    mPtr = 0; mAcc = 0; mStep = 20'hF0000;
    for (int i = 0; i < 40; i++) begin
      logic ld, nd, up;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      w  = lfsr[19:0];
      ld = (i == 0) || (i == 20);
      nd = (i % 7 == 3);
      up = lfsr[25];
      model(w, ld, (i < 20) ? 20'h26666 : 20'h25810, nd, up, eb, ev);
      runCycle(w, ld, (i < 20) ? 20'h26666 : 20'h25810, nd, up);
      check($sformatf("R3/R6/R7 frac bits %0d", i), recBits, eb);
      check($sformatf("R3 frac valid %0d", i), recValid, ev);
    end

    // R1: reset in mid-run clears outputs and state
    rst = 1'b1;
    runCycle(20'hFFFFF, 1'b0, 20'h0, 1'b0, 1'b0);
    check("R1 mid reset bits", recBits, 10'h000);
    check("R1 mid reset valid", recValid, 10'h000);
    rst = 1'b0;
    mPtr = 0; mAcc = 0; mStep = 20'h50000;
    for (int i = 0; i < 6; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      w = lfsr[19:0];
      model(w, 1'b0, 20'h0, 1'b0, 1'b0, eb, ev);
      runCycle(w, 1'b0, 20'h0, 1'b0, 1'b0);
      check($sformatf("R1 after reset bits %0d", i), recBits, eb);
      check($sformatf("R1 after reset valid %0d", i), recValid, ev);
    end

    // R7: earlier nudge at pointer 0 has no effect (step 5, pointer 0)
    runCycle(20'h08421, 1'b0, 20'h0, 1'b1, 1'b0);
    check("R7 saturate bits", recBits, 10'h00F);
    check("R7 saturate valid", recValid, 10'h00F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule